// File: doc/BRIEF.md
# Dual-Clock Mailbox Bridge

This block carries single command words between two ports that run on unrelated clocks, outside any data queue. Each direction has one 36-bit holding register and an active-low occupancy flag. The port that writes a register sees its flag in its own clock domain. The flag drops on the write and rises again once the opposite port has read the word.

Each port has a chip select, a direction bit (high means write), an enable and a mailbox select. A write with all four high loads the mailbox that port feeds. A read with mailbox select high takes the word from the mailbox the other port feeds and reports the read back across the clock boundary. A one-bit toggle passes through a two-flop synchronizer and is turned back into a pulse on the writer's side. While its flag is low, a mailbox refuses new writes, so the word never changes while the other clock is sampling it.

Each port's output bus is active whenever chip select is high and the direction is read. It then shows the mailbox when mailbox select is high and the queue output word supplied to the block when mailbox select is low. When the bus is not active it shows zero.

Top module: `mbox_bridge`

## Requirements
- R1: After reset both flags (`mbf1_n`, `mbf2_n`) are high and both mailboxes hold zero.
- R2: A port A rising edge with `cs_a`, `wr_a`, `en_a` and `mbsel_a` all high while `mbf1_n` is high stores `din_a` in mailbox 1. `mbf1_n` is low right after that edge.
- R3: A port B rising edge with `cs_b`, `wr_b`, `en_b` and `mbsel_b` all high while `mbf2_n` is high stores `din_b` in mailbox 2. `mbf2_n` is low right after that edge.
- R4: While a mailbox's flag is low, write attempts to it leave its contents and its flag unchanged.
- R5: A write attempt with any one of chip select, direction, enable or mailbox select low stores nothing and leaves the flag high.
- R6: A port B rising edge with `cs_b` high, `wr_b` low, `en_b` high and `mbsel_b` high counts as a mailbox 1 read. `mbf1_n` is still low after the second rising edge of `clk_a` that follows it and is high after the third.
- R7: A port A mailbox read (`cs_a` high, `wr_a` low, `en_a` high, `mbsel_a` high) makes `mbf2_n` still low after the second rising edge of `clk_b` that follows it and high after the third.
- R8: `act_x` equals chip select AND NOT direction. When it is high, `dout_x` shows the mailbox the other port writes if mailbox select is high, and `fifo_q_x` if mailbox select is low. When it is low, `dout_x` is zero.
- R9: Reading a mailbox leaves its contents unchanged. The same word is returned during the read and afterwards.
- R10: A read with enable or mailbox select low does not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| cs_a | input | 1 | Port A chip select |
| wr_a | input | 1 | Port A direction, 1 = write, 0 = read |
| en_a | input | 1 | Port A transfer enable |
| mbsel_a | input | 1 | Port A mailbox select |
| din_a | input | 36 | Port A write data |
| fifo_q_a | input | 36 | Queue output word shown on port A when mailbox select is low |
| dout_a | output | 36 | Port A read data |
| act_a | output | 1 | Port A output bus active |
| mbf1_n | output | 1 | Mailbox 1 flag, low = holding a word (clk_a domain) |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| cs_b | input | 1 | Port B chip select |
| wr_b | input | 1 | Port B direction, 1 = write, 0 = read |
| en_b | input | 1 | Port B transfer enable |
| mbsel_b | input | 1 | Port B mailbox select |
| din_b | input | 36 | Port B write data |
| fifo_q_b | input | 36 | Queue output word shown on port B when mailbox select is low |
| dout_b | output | 36 | Port B read data |
| act_b | output | 1 | Port B output bus active |
| mbf2_n | output | 1 | Mailbox 2 flag, low = holding a word (clk_b domain) |

## Verification
The writer's flag falls on the same edge that accepts the write, so the bench samples it 1 ns after that edge. The output bus is combinational, so it is checked 1 ns after the inputs change between clock edges, with enable low so that no transfer takes place. A read reaches the writer's flag through a synchronizer and an edge detector. The bench therefore counts rising edges of the writer's clock from the read edge and checks that the flag is still low after the second and high after the third. The two clocks are offset so that their edges never coincide, which makes that count exact.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_MB_WR = 2'd1,
        ACC_MB_RD = 2'd2,
        ACC_QUEUE = 2'd3
    } acc_e;

    function automatic acc_e mb_decode(input logic cs, input logic wr,
                                       input logic en, input logic mbsel);
        acc_e k;
        k = ACC_IDLE;
        if (cs && en) begin
            if (!mbsel)  k = ACC_QUEUE;
            else if (wr) k = ACC_MB_WR;
            else         k = ACC_MB_RD;
        end
        return k;
    endfunction

endpackage

// File: rtl/mbox_xsync.sv
module mbox_xsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], tgl_i};
        st_d.last = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.sh[STAGES-1] ^ st_q.last;
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int unsigned DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_e          acc_i,
    input  logic [DW-1:0] din_i,
    input  logic          clr_i,
    output logic [DW-1:0] data_o,
    output logic          full_n_o
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
    } st_t;

    st_t  st_d, st_q;
    logic take;

    always_comb begin
        st_d = st_q;
        take = (acc_i == ACC_MB_WR) && !st_q.full;
        if (take) begin
            st_d.data = din_i;
            st_d.full = 1'b1;
        end else if (clr_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o   = st_q.data;
    assign full_n_o = !st_q.full;
endmodule

// File: rtl/mbox_reader.sv
module mbox_reader
    import mbox_pkg::*;
#(
    parameter int unsigned DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          wr_i,
    input  logic          mbsel_i,
    input  acc_e          acc_i,
    input  logic [DW-1:0] mail_i,
    input  logic [DW-1:0] fifo_i,
    output logic [DW-1:0] dout_o,
    output logic          act_o,
    output logic          tgl_o
);
    typedef struct packed {
        logic tgl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_i == ACC_MB_RD) st_d.tgl = !st_q.tgl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        act_o  = cs_i && !wr_i;
        dout_o = '0;
        if (act_o) dout_o = mbsel_i ? mail_i : fifo_i;
    end

    assign tgl_o = st_q.tgl;
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk_a,
    input  logic          rst_a_n,
    input  logic          cs_a,
    input  logic          wr_a,
    input  logic          en_a,
    input  logic          mbsel_a,
    input  logic [DW-1:0] din_a,
    input  logic [DW-1:0] fifo_q_a,
    output logic [DW-1:0] dout_a,
    output logic          act_a,
    output logic          mbf1_n,
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic          cs_b,
    input  logic          wr_b,
    input  logic          en_b,
    input  logic          mbsel_b,
    input  logic [DW-1:0] din_b,
    input  logic [DW-1:0] fifo_q_b,
    output logic [DW-1:0] dout_b,
    output logic          act_b,
    output logic          mbf2_n
);
    acc_e          acc_a, acc_b;
    logic [DW-1:0] mail1, mail2;
    logic          rd1_tgl, rd2_tgl;
    logic          clr1, clr2;

    assign acc_a = mb_decode(cs_a, wr_a, en_a, mbsel_a);
    assign acc_b = mb_decode(cs_b, wr_b, en_b, mbsel_b);

    // Mailbox 1: written and flagged in the A domain, read from B
    mbox_slot #(.DW(DW)) u_slot1 (
        .clk(clk_a), .rst_n(rst_a_n), .acc_i(acc_a), .din_i(din_a),
        .clr_i(clr1), .data_o(mail1), .full_n_o(mbf1_n)
    );
    mbox_reader #(.DW(DW)) u_rd_b (
        .clk(clk_b), .rst_n(rst_b_n), .cs_i(cs_b), .wr_i(wr_b),
        .mbsel_i(mbsel_b), .acc_i(acc_b), .mail_i(mail1), .fifo_i(fifo_q_b),
        .dout_o(dout_b), .act_o(act_b), .tgl_o(rd1_tgl)
    );
    mbox_xsync #(.STAGES(STAGES)) u_sync1 (
        .clk(clk_a), .rst_n(rst_a_n), .tgl_i(rd1_tgl), .pulse_o(clr1)
    );

    // Mailbox 2: written and flagged in the B domain, read from A
    mbox_slot #(.DW(DW)) u_slot2 (
        .clk(clk_b), .rst_n(rst_b_n), .acc_i(acc_b), .din_i(din_b),
        .clr_i(clr2), .data_o(mail2), .full_n_o(mbf2_n)
    );
    mbox_reader #(.DW(DW)) u_rd_a (
        .clk(clk_a), .rst_n(rst_a_n), .cs_i(cs_a), .wr_i(wr_a),
        .mbsel_i(mbsel_a), .acc_i(acc_a), .mail_i(mail2), .fifo_i(fifo_q_a),
        .dout_o(dout_a), .act_o(act_a), .tgl_o(rd2_tgl)
    );
    mbox_xsync #(.STAGES(STAGES)) u_sync2 (
        .clk(clk_b), .rst_n(rst_b_n), .tgl_i(rd2_tgl), .pulse_o(clr2)
    );
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk #(
    parameter int unsigned DW = 36
) (
    input logic          clk_a,
    input logic          rst_a_n,
    input logic          cs_a,
    input logic          wr_a,
    input logic          en_a,
    input logic          mbsel_a,
    input logic          mbf1_n,
    input logic [DW-1:0] mail1,
    input logic          clk_b,
    input logic          rst_b_n,
    input logic          cs_b,
    input logic          wr_b,
    input logic          en_b,
    input logic          mbsel_b,
    input logic          mbf2_n,
    input logic [DW-1:0] mail2
);
    logic try_a, try_b;
    assign try_a = cs_a && wr_a && en_a && mbsel_a;
    assign try_b = cs_b && wr_b && en_b && mbsel_b;

    a_r2_write_fills: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (try_a && mbf1_n) |=> !mbf1_n);
    a_r5_fall_needs_write_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $fell(mbf1_n) |-> $past(try_a));
    a_r4_hold_mail1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !mbf1_n |=> $stable(mail1));
    a_r3_write_fills: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (try_b && mbf2_n) |=> !mbf2_n);
    a_r5_fall_needs_write_b: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $fell(mbf2_n) |-> $past(try_b));
    a_r4_hold_mail2: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !mbf2_n |=> $stable(mail2));
endmodule

bind mbox_bridge mbox_bridge_chk #(.DW(DW)) u_chk (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a(cs_a), .wr_a(wr_a), .en_a(en_a),
    .mbsel_a(mbsel_a), .mbf1_n(mbf1_n), .mail1(mail1),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b(cs_b), .wr_b(wr_b), .en_b(en_b),
    .mbsel_b(mbsel_b), .mbf2_n(mbf2_n), .mail2(mail2)
);

// File: tb/sim_mbox_bridge.sv
`timescale 1ns/1ps
module sim_mbox_bridge;
    localparam int DW = 36;

    logic          clk_a = 1'b0, clk_b = 1'b0;
    logic          rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic          cs_a = 0, wr_a = 0, en_a = 0, mbsel_a = 0;
    logic          cs_b = 0, wr_b = 0, en_b = 0, mbsel_b = 0;
    logic [DW-1:0] din_a = '0, din_b = '0;
    logic [DW-1:0] fifo_q_a = 36'h9_ABCD_EF01, fifo_q_b = 36'h3_1415_9265;
    logic [DW-1:0] dout_a, dout_b;
    logic          act_a, act_b, mbf1_n, mbf2_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // A: 50 MHz, rising edges at 10+20k. B: rising edges at 5+30k; never coincident.
    always #10 clk_a = ~clk_a;
    initial begin
        #20;
        forever #15 clk_b = ~clk_b;
    end

    mbox_bridge u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a(cs_a), .wr_a(wr_a), .en_a(en_a),
        .mbsel_a(mbsel_a), .din_a(din_a), .fifo_q_a(fifo_q_a), .dout_a(dout_a),
        .act_a(act_a), .mbf1_n(mbf1_n),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b(cs_b), .wr_b(wr_b), .en_b(en_b),
        .mbsel_b(mbsel_b), .din_b(din_b), .fifo_q_b(fifo_q_b), .dout_b(dout_b),
        .act_b(act_b), .mbf2_n(mbf2_n)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i) * 36'h0_1357_9BDF + 36'h1_0000_0001;
    endfunction

    task automatic a_op(input logic c, w, e, m, input logic [DW-1:0] d);
        @(negedge clk_a); cs_a = c; wr_a = w; en_a = e; mbsel_a = m; din_a = d;
        @(posedge clk_a); #1;
        @(negedge clk_a); cs_a = 0; wr_a = 0; en_a = 0; mbsel_a = 0;
    endtask

    task automatic b_op(input logic c, w, e, m, input logic [DW-1:0] d);
        @(negedge clk_b); cs_b = c; wr_b = w; en_b = e; mbsel_b = m; din_b = d;
        @(posedge clk_b); #1;
        @(negedge clk_b); cs_b = 0; wr_b = 0; en_b = 0; mbsel_b = 0;
    endtask

    // bus active, enable low: no transfer, mailbox visible
    task automatic peek_b(output logic [DW-1:0] v);
        @(negedge clk_b); cs_b = 1; wr_b = 0; en_b = 0; mbsel_b = 1;
        #1 v = dout_b;
        cs_b = 0; mbsel_b = 0;
    endtask

    task automatic peek_a(output logic [DW-1:0] v);
        @(negedge clk_a); cs_a = 1; wr_a = 0; en_a = 0; mbsel_a = 1;
        #1 v = dout_a;
        cs_a = 0; mbsel_a = 0;
    endtask

    task automatic wait_a(input int n);
        for (int k = 0; k < n; k++) @(posedge clk_a);
        #1;
    endtask

    task automatic wait_b(input int n);
        for (int k = 0; k < n; k++) @(posedge clk_b);
        #1;
    endtask

    // R6 / R9: B reads mailbox 1, count A edges to the flag rise
    task automatic b_read_timed(input logic [DW-1:0] exp);
        @(negedge clk_b); cs_b = 1; wr_b = 0; en_b = 1; mbsel_b = 1;
        #1 chk(dout_b == exp, "R9 read data", dout_b, exp);
        @(posedge clk_b);
        fork
            begin
                @(negedge clk_b); cs_b = 0; en_b = 0; mbsel_b = 0;
            end
            begin
                wait_a(2);
                chk(mbf1_n == 1'b0, "R6 low after 2 edges", DW'(mbf1_n), '0);
                wait_a(1);
                chk(mbf1_n == 1'b1, "R6 high after 3 edges", DW'(mbf1_n), 1);
            end
        join
    endtask

    task automatic a_read_timed(input logic [DW-1:0] exp);
        @(negedge clk_a); cs_a = 1; wr_a = 0; en_a = 1; mbsel_a = 1;
        #1 chk(dout_a == exp, "R9 read data", dout_a, exp);
        @(posedge clk_a);
        fork
            begin
                @(negedge clk_a); cs_a = 0; en_a = 0; mbsel_a = 0;
            end
            begin
                wait_b(2);
                chk(mbf2_n == 1'b0, "R7 low after 2 edges", DW'(mbf2_n), '0);
                wait_b(1);
                chk(mbf2_n == 1'b1, "R7 high after 3 edges", DW'(mbf2_n), 1);
            end
        join
    endtask

    initial begin : watchdog
        for (int k = 0; k < 150000; k++) @(posedge clk_a);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin : main
        logic [DW-1:0] v, e;
        #103;
        rst_a_n = 1; rst_b_n = 1;
        wait_a(2);

        // R1 reset state
        chk(mbf1_n == 1'b1, "R1 flag1", DW'(mbf1_n), 1);
        chk(mbf2_n == 1'b1, "R1 flag2", DW'(mbf2_n), 1);
        peek_a(v); chk(v == '0, "R1 mailbox2", v, '0);
        peek_b(v); chk(v == '0, "R1 mailbox1", v, '0);

        // R8 output mux sweep on both ports (enable low: no transfer)
        for (int k = 0; k < 8; k++) begin
            @(negedge clk_a); cs_a = k[0]; wr_a = k[1]; mbsel_a = k[2]; en_a = 0;
            #1;
            e = (k[0] && !k[1]) ? (k[2] ? 36'h0 : fifo_q_a) : 36'h0;
            chk(dout_a == e, "R8 port A mux", dout_a, e);
            chk(act_a == (k[0] && !k[1]), "R8 port A active", DW'(act_a), DW'(k[0] && !k[1]));
            cs_a = 0; wr_a = 0; mbsel_a = 0;
            @(negedge clk_b); cs_b = k[0]; wr_b = k[1]; mbsel_b = k[2]; en_b = 0;
            #1;
            e = (k[0] && !k[1]) ? (k[2] ? 36'h0 : fifo_q_b) : 36'h0;
            chk(dout_b == e, "R8 port B mux", dout_b, e);
            chk(act_b == (k[0] && !k[1]), "R8 port B active", DW'(act_b), DW'(k[0] && !k[1]));
            cs_b = 0; wr_b = 0; mbsel_b = 0;
        end

        // R5 every incomplete write qualifier on port A and port B
        for (int k = 0; k < 15; k++) begin
            a_op(k[0], k[1], k[2], k[3], 36'hD_EAD0_BEEF);
            chk(mbf1_n == 1'b1, "R5 flag1 stays high", DW'(mbf1_n), 1);
            b_op(k[0], k[1], k[2], k[3], 36'hC_AFE0_F00D);
            chk(mbf2_n == 1'b1, "R5 flag2 stays high", DW'(mbf2_n), 1);
        end
        wait_a(6); wait_b(6);
        peek_b(v); chk(v == '0, "R5 mailbox1 untouched", v, '0);
        peek_a(v); chk(v == '0, "R5 mailbox2 untouched", v, '0);

        for (int i = 0; i < 6; i++) begin
            // R2 port A write
            a_op(1, 1, 1, 1, pat(i));
            chk(mbf1_n == 1'b0, "R2 flag1 low", DW'(mbf1_n), '0);
            peek_b(v); chk(v == pat(i), "R2 mailbox1 data", v, pat(i));
            // R4 locked write
            a_op(1, 1, 1, 1, ~pat(i));
            chk(mbf1_n == 1'b0, "R4 flag1 low", DW'(mbf1_n), '0);
            peek_b(v); chk(v == pat(i), "R4 mailbox1 kept", v, pat(i));
            // R10 non-reads
            b_op(1, 0, 0, 1, '0);
            b_op(1, 0, 1, 0, '0);
            wait_a(5);
            chk(mbf1_n == 1'b0, "R10 flag1 stays low", DW'(mbf1_n), '0);
            // R6 timed read
            b_read_timed(pat(i));
            peek_b(v); chk(v == pat(i), "R9 mailbox1 after read", v, pat(i));

            // R3 port B write
            b_op(1, 1, 1, 1, pat(i + 20));
            chk(mbf2_n == 1'b0, "R3 flag2 low", DW'(mbf2_n), '0);
            peek_a(v); chk(v == pat(i + 20), "R3 mailbox2 data", v, pat(i + 20));
            b_op(1, 1, 1, 1, ~pat(i + 20));
            chk(mbf2_n == 1'b0, "R4 flag2 low", DW'(mbf2_n), '0);
            peek_a(v); chk(v == pat(i + 20), "R4 mailbox2 kept", v, pat(i + 20));
            a_op(1, 0, 0, 1, '0);
            a_op(1, 0, 1, 0, '0);
            wait_b(5);
            chk(mbf2_n == 1'b0, "R10 flag2 stays low", DW'(mbf2_n), '0);
            a_read_timed(pat(i + 20));
            peek_a(v); chk(v == pat(i + 20), "R9 mailbox2 after read", v, pat(i + 20));
        end

        done = 1;
        report();
    end
endmodule